// File: doc/BRIEF.md
# Parallel Host Bus Front End for a Display Controller

This block connects a host processor's parallel bus to the core of a small display controller. Two pin straps configure it. One selects the strobe style: either separate active-low write and read strobes, or a direction level qualified by a high enable pulse. The other selects a full-byte or a half-byte data path. Each completed host access becomes one of four operations: a command write, a status read, a display-RAM write or a display-RAM read. Command writes leave the block as a one-cycle strobe with its byte. RAM traffic leaves on a synchronous single-port RAM interface.

The host signals are asynchronous to the core clock and pass through a two-flop synchroniser. An access completes on the trailing edge of its strobe. A column pointer inside the block addresses the RAM. The command decoder loads it through a load pulse when it executes a set-address command, and every data transfer advances it. Read data is served from a prefetch register. After each address load the host must make one throw-away read before valid data appears.

Top module: `disp_host_port`

## Requirements
- R1: While reset is held low and directly after it is released, `dout_oe`, `ram_we`, `ram_re` and `cmd_we` are low and `ram_addr` is 0.
- R2: A completed write with `cd` low raises `cmd_we` for exactly one cycle, with the written byte on `cmd_data`. The RAM is not written.
- R3: With `bus_style`=1, a high pulse on `rd_en` is a write when `we_rw`=0 and a read when `we_rw`=1. The access completes when `rd_en` falls. With `bus_style`=0, a low pulse on `we_rw` is a write and a low pulse on `rd_en` is a read. Each completes when its strobe rises.
- R4: While `cs_n` is high, strobes cause no command strobe, no RAM write, no change of `ram_addr`, and `dout_oe` stays low.
- R5: A completed write with `cd` high raises `ram_we` for one cycle, with the byte on `ram_wdata` and the current column on `ram_addr`. The column then advances by one. `ram_we` and `cmd_we` are never high together.
- R6: After an address load, the first data read returns a throw-away value and does not move the column. Each later data read returns the RAM byte at the current column and then advances the column by one. A data write also makes the next read a throw-away read.
- R7: When the column is at COLS-1, an advance sets it to 0.
- R8: With `narrow`=1, only `din[3:0]` and `dout[3:0]` carry data and `dout[7:4]` reads 0. Every byte takes two accesses, the high nibble first. The byte-level action, including the throw-away read, happens on the second access.
- R9: With `narrow`=1, any change of `cd` while `cs_n` is low makes the next access a high-nibble access.
- R10: With `narrow`=1, deasserting `cs_n` makes the next access a high-nibble access.
- R11: `dout_oe` is high only while the chip is selected and a read is in progress. During a read with `cd` low, `dout` shows `status_in`.
- R12: If an address load arrives in the same cycle as the completion of a data read, the loaded column wins and the next data read is a throw-away read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_style | input | 1 | Strap: 0 = separate write/read strobes, 1 = direction level plus enable |
| narrow | input | 1 | Strap: 0 = byte-wide bus, 1 = nibble-wide bus |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| cd | input | 1 | 0 = command/status, 1 = display data |
| we_rw | input | 1 | Write strobe (active low) or direction level (1 = read) |
| rd_en | input | 1 | Read strobe (active low) or enable pulse (active high) |
| din | input | DW | Host write data |
| dout | output | DW | Host read data |
| dout_oe | output | 1 | Read data output enable |
| status_in | input | DW | Status byte from the core |
| addr_set | input | 1 | One-cycle column load pulse from the command decoder |
| addr_col | input | AW | Column value to load (below COLS) |
| cmd_we | output | 1 | Command byte strobe |
| cmd_data | output | DW | Command byte |
| ram_we | output | 1 | RAM write enable |
| ram_re | output | 1 | RAM read enable, data expected one cycle later |
| ram_addr | output | AW | RAM column address |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data |

## Verification
Two events can land on the same clock edge: an address load pulse from the command decoder, and the completion of a host data read that would advance the column. The bench provokes this by releasing the read strobe and then raising `addr_set` exactly two clocks later, in the cycle where the synchronised strobe edge is detected. The result is judged at the ports. The collided read must still return the byte it was serving, and `ram_addr` must show the loaded column. The next read must be a throw-away read, and the read after that must return the RAM byte at the loaded column.

// File: rtl/dhp_pkg.sv
// Shared definitions for the display host port.
// Assumes: byte-wide data split into two equal nibbles in narrow mode.
package dhp_pkg;

    // Strap encoding of the strobe style
    typedef enum logic {
        STYLE_SPLIT_STROBE = 1'b0,
        STYLE_DIR_ENABLE   = 1'b1
    } bus_style_e;

    // Bit positions inside the synchroniser bundle
    localparam int SB_CS = 0;
    localparam int SB_CD = 1;
    localparam int SB_WE = 2;
    localparam int SB_RD = 3;
    localparam int SB_DIN = 4;

endpackage

// File: rtl/dhp_sync.sv
// Two-flop synchroniser for a bundle of asynchronous host pins.
// Assumes: each bit is quasi-static relative to its strobe; RST_VAL gives the
// per-bit value held during reset.
module dhp_sync #(
    parameter int W = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            logic meta_q;
            logic sync_q;
            // Two-stage capture of one pin into the core domain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= RST_VAL[b];
                    sync_q <= RST_VAL[b];
                end else begin
                    meta_q <= async_in[b];
                    sync_q <= meta_q;
                end
            end
            assign sync_out[b] = sync_q;
        end
    endgenerate

endmodule

// File: rtl/dhp_strobe_decode.sv
// Turns synchronised host pins into access levels and one-cycle completion
// pulses. Completion is the trailing edge of the strobe, qualified by chip
// select. Assumes: strobes are held at least three core clocks.
module dhp_strobe_decode
    import dhp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  bus_style_e style,
    input  logic       cs_act,
    input  logic       we_pin,
    input  logic       rd_pin,
    output logic       wr_lvl,
    output logic       rd_lvl,
    output logic       wr_done,
    output logic       rd_done
);

    logic wr_prev, rd_prev;
    logic wr_idle_seen, rd_idle_seen;

    // Level decode for both strobe styles
    always_comb begin
        if (style == STYLE_DIR_ENABLE) begin
            wr_lvl = rd_pin & ~we_pin;
            rd_lvl = rd_pin & we_pin;
        end else begin
            wr_lvl = ~we_pin;
            rd_lvl = ~rd_pin;
        end
    end

    // Previous levels; an edge counts only once an idle level has been seen
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_prev      <= 1'b0;
            rd_prev      <= 1'b0;
            wr_idle_seen <= 1'b0;
            rd_idle_seen <= 1'b0;
        end else begin
            wr_idle_seen <= wr_idle_seen | ~wr_lvl;
            rd_idle_seen <= rd_idle_seen | ~rd_lvl;
            wr_prev      <= wr_lvl & wr_idle_seen;
            rd_prev      <= rd_lvl & rd_idle_seen;
        end
    end

    assign wr_done = wr_prev & ~wr_lvl & cs_act;
    assign rd_done = rd_prev & ~rd_lvl & cs_act;

    assert_done_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_done && rd_done));

endmodule

// File: rtl/dhp_nibble.sv
// Nibble phase tracking and byte assembly. In byte mode every access is a
// whole byte. In nibble mode accesses alternate high/low; the phase returns
// to high on chip-select loss or on any command/data change while selected.
module dhp_nibble #(
    parameter int DW = 8,
    parameter int HALF = DW / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          narrow,
    input  logic          cs_act,
    input  logic          cd,
    input  logic          wr_done,
    input  logic          rd_done,
    input  logic [DW-1:0] din,
    output logic          phase_lo,
    output logic [DW-1:0] wbyte,
    output logic          wbyte_done,
    output logic          rbyte_done
);

    logic            cd_prev;
    logic [HALF-1:0] hi_nib;

    // Phase register with resynchronisation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_lo <= 1'b0;
            cd_prev  <= 1'b1;
        end else begin
            cd_prev <= cd;
            if (!cs_act || !narrow)
                phase_lo <= 1'b0;
            else if (cd != cd_prev)
                phase_lo <= 1'b0;
            else if (wr_done || rd_done)
                phase_lo <= ~phase_lo;
        end
    end

    // Hold the high nibble until the low one arrives
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_nib <= '0;
        else if (narrow && wr_done && !phase_lo)
            hi_nib <= din[HALF-1:0];
    end

    assign wbyte      = narrow ? {hi_nib, din[HALF-1:0]} : din;
    assign wbyte_done = wr_done & (~narrow | phase_lo);
    assign rbyte_done = rd_done & (~narrow | phase_lo);

    assert_phase_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !phase_lo);

    assert_phase_resync_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && (cd != $past(cd))) |=> !phase_lo);

endmodule

// File: rtl/dhp_colpipe.sv
// Column pointer, RAM write port and two-stage read pipeline. Stage one is
// the synchronous RAM read; stage two is the prefetch register the host
// reads. A load or a write marks the prefetch stale, so the next read is a
// throw-away read that only refills it. Assumes: loaded columns are < COLS.
module dhp_colpipe #(
    parameter int COLS = 104,
    parameter int DW = 8,
    parameter int AW = $clog2(COLS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_set,
    input  logic [AW-1:0] addr_col,
    input  logic          data_wr,
    input  logic [DW-1:0] wbyte,
    input  logic          data_rd,
    input  logic [DW-1:0] ram_rdata,
    output logic          ram_we,
    output logic          ram_re,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    output logic [DW-1:0] prefetch
);

    localparam logic [AW-1:0] LAST_COL = AW'(COLS - 1);

    logic [AW-1:0] col, waddr_q, col_next;
    logic          stale, fetch_d;

    assign col_next = (col == LAST_COL) ? '0 : col + 1'b1;

    // Column pointer and stale-prefetch flag; a load has priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col   <= '0;
            stale <= 1'b1;
        end else if (addr_set) begin
            col   <= addr_col;
            stale <= 1'b1;
        end else if (data_wr) begin
            col   <= col_next;
            stale <= 1'b1;
        end else if (data_rd) begin
            if (stale)
                stale <= 1'b0;
            else
                col <= col_next;
        end
    end

    // Write port: capture byte and column of the completed write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_we    <= 1'b0;
            waddr_q   <= '0;
            ram_wdata <= '0;
        end else begin
            ram_we <= data_wr;
            if (data_wr) begin
                waddr_q   <= col;
                ram_wdata <= wbyte;
            end
        end
    end

    // Read pipeline: request after each read, load prefetch a cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_re   <= 1'b0;
            fetch_d  <= 1'b0;
            prefetch <= '0;
        end else begin
            ram_re  <= data_rd;
            fetch_d <= ram_re;
            if (fetch_d)
                prefetch <= ram_rdata;
        end
    end

    assign ram_addr = ram_we ? waddr_q : col;

    assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_set && data_wr && col == LAST_COL) |=> (col == '0));

    assert_load_stale_R12: assert property (@(posedge clk) disable iff (!rst_n)
        addr_set |=> (stale && col == $past(addr_col)));

    assert_we_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we);

endmodule

// File: rtl/disp_host_port.sv
// Parallel host bus front end of a display controller. Synchronises the
// host pins, decodes the strobe style, assembles nibbles and routes each
// completed access to the command strobe, the status path or the display
// RAM. Assumes: straps are static; strobes last three or more core clocks.
module disp_host_port
    import dhp_pkg::*;
#(
    parameter int COLS = 104,
    parameter int DW = 8,
    parameter int AW = $clog2(COLS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_style,
    input  logic          narrow,
    input  logic          cs_n,
    input  logic          cd,
    input  logic          we_rw,
    input  logic          rd_en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_oe,
    input  logic [DW-1:0] status_in,
    input  logic          addr_set,
    input  logic [AW-1:0] addr_col,
    output logic          cmd_we,
    output logic [DW-1:0] cmd_data,
    output logic          ram_we,
    output logic          ram_re,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    input  logic [DW-1:0] ram_rdata
);

    localparam int HALF = DW / 2;
    localparam int SW = SB_DIN + DW;
    localparam logic [SW-1:0] SYNC_RST = {{DW{1'b0}}, 4'b1111};

    logic [SW-1:0] raw_bus, sync_bus;
    logic          cs_act, cd_s;
    logic          wr_lvl, rd_lvl, wr_done, rd_done;
    logic          phase_lo, wbyte_done, rbyte_done;
    logic [DW-1:0] wbyte, prefetch, rsel;
    bus_style_e    style;

    assign raw_bus = {din, rd_en, we_rw, cd, cs_n};
    assign style   = bus_style_e'(bus_style);

    dhp_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_bus),
        .sync_out (sync_bus)
    );

    assign cs_act = ~sync_bus[SB_CS];
    assign cd_s   = sync_bus[SB_CD];

    dhp_strobe_decode u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .style   (style),
        .cs_act  (cs_act),
        .we_pin  (sync_bus[SB_WE]),
        .rd_pin  (sync_bus[SB_RD]),
        .wr_lvl  (wr_lvl),
        .rd_lvl  (rd_lvl),
        .wr_done (wr_done),
        .rd_done (rd_done)
    );

    dhp_nibble #(.DW(DW)) u_nibble (
        .clk        (clk),
        .rst_n      (rst_n),
        .narrow     (narrow),
        .cs_act     (cs_act),
        .cd         (cd_s),
        .wr_done    (wr_done),
        .rd_done    (rd_done),
        .din        (sync_bus[SW-1:SB_DIN]),
        .phase_lo   (phase_lo),
        .wbyte      (wbyte),
        .wbyte_done (wbyte_done),
        .rbyte_done (rbyte_done)
    );

    dhp_colpipe #(.COLS(COLS), .DW(DW), .AW(AW)) u_colpipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_set  (addr_set),
        .addr_col  (addr_col),
        .data_wr   (wbyte_done & cd_s),
        .wbyte     (wbyte),
        .data_rd   (rbyte_done & cd_s),
        .ram_rdata (ram_rdata),
        .ram_we    (ram_we),
        .ram_re    (ram_re),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .prefetch  (prefetch)
    );

    // Command strobe for completed writes with cd low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_we   <= 1'b0;
            cmd_data <= '0;
        end else begin
            cmd_we <= wbyte_done & ~cd_s;
            if (wbyte_done && !cd_s)
                cmd_data <= wbyte;
        end
    end

    // Read data selection and nibble split
    always_comb begin
        rsel = cd_s ? prefetch : status_in;
        if (narrow)
            dout = {{(DW - HALF){1'b0}}, phase_lo ? rsel[HALF-1:0] : rsel[DW-1:HALF]};
        else
            dout = rsel;
    end

    assign dout_oe = cs_act & rd_lvl;

    assert_cmd_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we |=> !cmd_we);

    assert_we_cmd_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_we && ram_we));

    assert_oe_needs_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) && cs_n |-> !dout_oe);

endmodule

// File: tb/sim_disp_host_port.sv
// Directed bench for disp_host_port; one task per scenario.
module sim_disp_host_port;

    localparam int COLS = 104;
    localparam int DW = 8;
    localparam int AW = $clog2(COLS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_style = 1'b0;
    logic          narrow = 1'b0;
    logic          cs_n = 1'b1;
    logic          cd = 1'b1;
    logic          we_rw = 1'b1;
    logic          rd_en = 1'b1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_oe;
    logic [DW-1:0] status_in = 8'h5A;
    logic          addr_set = 1'b0;
    logic [AW-1:0] addr_col = '0;
    logic          cmd_we;
    logic [DW-1:0] cmd_data;
    logic          ram_we;
    logic          ram_re;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata;
    logic [DW-1:0] ram_rdata = '0;

    int checks = 0;
    int failures = 0;
    int cmd_cnt = 0;
    int we_cnt = 0;
    logic [DW-1:0] last_cmd = '0;
    logic [DW-1:0] mem [COLS];

    always #4 clk = ~clk;

    disp_host_port #(.COLS(COLS), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_style(bus_style), .narrow(narrow),
        .cs_n(cs_n), .cd(cd), .we_rw(we_rw), .rd_en(rd_en), .din(din),
        .dout(dout), .dout_oe(dout_oe), .status_in(status_in),
        .addr_set(addr_set), .addr_col(addr_col), .cmd_we(cmd_we),
        .cmd_data(cmd_data), .ram_we(ram_we), .ram_re(ram_re),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // RAM model and command monitor
    always @(posedge clk) begin
        if (ram_we) begin
            mem[ram_addr] <= ram_wdata;
            we_cnt <= we_cnt + 1;
        end
        if (ram_re)
            ram_rdata <= mem[ram_addr];
        if (cmd_we) begin
            cmd_cnt <= cmd_cnt + 1;
            last_cmd <= cmd_data;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // One host access (nibble or byte) in the current strobe style
    task automatic host_xfer(input bit is_rd, input bit cdv, input logic [7:0] wv,
                             output logic [7:0] rv, output bit oe);
        @(negedge clk);
        cd = cdv;
        din = wv;
        if (bus_style) begin
            we_rw = is_rd;
            @(negedge clk);
            rd_en = 1'b1;
        end else begin
            @(negedge clk);
            if (is_rd) rd_en = 1'b0; else we_rw = 1'b0;
        end
        repeat (5) @(negedge clk);
        rv = dout;
        oe = dout_oe;
        if (bus_style) rd_en = 1'b0;
        else begin rd_en = 1'b1; we_rw = 1'b1; end
        repeat (5) @(negedge clk);
        if (bus_style) we_rw = 1'b1;
    endtask

    // One byte, split into two nibbles in narrow mode
    task automatic xfer_byte(input bit is_rd, input bit cdv, input logic [7:0] wv,
                             output logic [7:0] rv, output bit oe);
        logic [7:0] r1, r2;
        bit o1, o2;
        if (narrow) begin
            host_xfer(is_rd, cdv, {4'h0, wv[7:4]}, r1, o1);
            host_xfer(is_rd, cdv, {4'h0, wv[3:0]}, r2, o2);
            rv = (r1[7:4] != 0 || r2[7:4] != 0) ? 8'hFF : {r1[3:0], r2[3:0]};
            oe = o1 & o2;
        end else begin
            host_xfer(is_rd, cdv, wv, rv, oe);
        end
    endtask

    task automatic set_col(input int c);
        @(negedge clk);
        addr_col = AW'(c);
        addr_set = 1'b1;
        @(negedge clk);
        addr_set = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic strap(input bit style, input bit nar);
        @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        bus_style = style;
        narrow = nar;
        we_rw = 1'b1;
        rd_en = style ? 1'b0 : 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(!dout_oe && !ram_we && !ram_re && !cmd_we, "R1 outputs idle in reset",
              {dout_oe, ram_we, ram_re, cmd_we}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(ram_addr == 0 && !dout_oe && !cmd_we, "R1 idle after reset", ram_addr, 0);
    endtask

    task automatic t_cmd_status();
        logic [7:0] rv; bit oe;
        int c0 = cmd_cnt, w0 = we_cnt;
        xfer_byte(1'b0, 1'b0, 8'hA5, rv, oe);
        check(cmd_cnt == c0 + 1 && last_cmd == 8'hA5, "R2 command write", last_cmd, 8'hA5);
        check(we_cnt == w0, "R2 no RAM write on command", we_cnt, w0);
        xfer_byte(1'b1, 1'b0, 8'h00, rv, oe);
        check(rv == 8'h5A, "R11 status read", rv, 8'h5A);
        check(oe == 1'b1, "R11 oe during read", oe, 1);
        check(dout_oe == 1'b0, "R11 oe off after read", dout_oe, 0);
    endtask

    task automatic t_write();
        logic [7:0] rv; bit oe;
        set_col(5);
        xfer_byte(1'b0, 1'b1, 8'h11, rv, oe);
        xfer_byte(1'b0, 1'b1, 8'h22, rv, oe);
        xfer_byte(1'b0, 1'b1, 8'h33, rv, oe);
        check(mem[5] == 8'h11 && mem[6] == 8'h22 && mem[7] == 8'h33, "R5 data writes",
              {mem[5], mem[6], mem[7]}, 24'h112233);
        check(ram_addr == 8, "R5 column advance", ram_addr, 8);
    endtask

    task automatic t_read();
        logic [7:0] rv; bit oe;
        set_col(5);
        xfer_byte(1'b1, 1'b1, 8'h00, rv, oe);
        check(ram_addr == 5, "R6 throw-away read keeps column", ram_addr, 5);
        xfer_byte(1'b1, 1'b1, 8'h00, rv, oe);
        check(rv == 8'h11, "R6 first valid read", rv, 8'h11);
        xfer_byte(1'b1, 1'b1, 8'h00, rv, oe);
        check(rv == 8'h22, "R6 second valid read", rv, 8'h22);
        check(ram_addr == 7, "R6 column after reads", ram_addr, 7);
    endtask

    task automatic t_enable_style();
        logic [7:0] rv; bit oe;
        int c0;
        strap(1'b1, 1'b0);
        c0 = cmd_cnt;
        xfer_byte(1'b0, 1'b0, 8'h3C, rv, oe);
        check(cmd_cnt == c0 + 1 && last_cmd == 8'h3C, "R3 enable-style command", last_cmd, 8'h3C);
        set_col(10);
        xfer_byte(1'b0, 1'b1, 8'h77, rv, oe);
        check(mem[10] == 8'h77, "R3 enable-style data write", mem[10], 8'h77);
        set_col(10);
        xfer_byte(1'b1, 1'b1, 8'h00, rv, oe);
        xfer_byte(1'b1, 1'b1, 8'h00, rv, oe);
        check(rv == 8'h77 && oe, "R3 enable-style read", rv, 8'h77);
        strap(1'b0, 1'b0);
    endtask

    task automatic t_deselect();
        logic [7:0] rv; bit oe;
        int c0, w0;
        logic [AW-1:0] a0;
        set_col(12);
        @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        c0 = cmd_cnt; w0 = we_cnt; a0 = ram_addr;
        xfer_byte(1'b0, 1'b0, 8'h99, rv, oe);
        xfer_byte(1'b0, 1'b1, 8'h99, rv, oe);
        xfer_byte(1'b1, 1'b1, 8'h00, rv, oe);
        check(cmd_cnt == c0 && we_cnt == w0, "R4 no effect while deselected",
              cmd_cnt + we_cnt, c0 + w0);
        check(ram_addr == a0, "R4 column unchanged", ram_addr, a0);
        check(oe == 1'b0, "R4 oe low while deselected", oe, 0);
        @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_wrap();
        logic [7:0] rv; bit oe;
        set_col(COLS - 1);
        xfer_byte(1'b0, 1'b1, 8'hEE, rv, oe);
        check(mem[COLS-1] == 8'hEE, "R7 write at last column", mem[COLS-1], 8'hEE);
        check(ram_addr == 0, "R7 wrap to zero", ram_addr, 0);
    endtask

    task automatic t_nibble();
        logic [7:0] rv; bit oe;
        strap(1'b0, 1'b1);
        set_col(20);
        xfer_byte(1'b0, 1'b1, 8'h4B, rv, oe);
        check(mem[20] == 8'h4B, "R8 nibble write", mem[20], 8'h4B);
        check(ram_addr == 21, "R8 one advance per byte", ram_addr, 21);
        set_col(20);
        xfer_byte(1'b1, 1'b1, 8'h00, rv, oe);
        check(ram_addr == 20, "R8 throw-away read takes two nibbles", ram_addr, 20);
        xfer_byte(1'b1, 1'b1, 8'h00, rv, oe);
        check(rv == 8'h4B, "R8 nibble read", rv, 8'h4B);
    endtask

    task automatic t_resync();
        logic [7:0] rv; bit oe;
        int c0;
        set_col(30);
        c0 = cmd_cnt;
        host_xfer(1'b0, 1'b1, 8'h07, rv, oe);
        @(negedge clk); cd = 1'b0;
        repeat (4) @(negedge clk); cd = 1'b1;
        repeat (4) @(negedge clk);
        xfer_byte(1'b0, 1'b1, 8'h5C, rv, oe);
        check(mem[30] == 8'h5C, "R9 resync on cd change", mem[30], 8'h5C);
        check(cmd_cnt == c0, "R9 no command from cd toggle", cmd_cnt, c0);
    endtask

    task automatic t_cs_phase();
        logic [7:0] rv; bit oe;
        set_col(40);
        host_xfer(1'b0, 1'b1, 8'h01, rv, oe);
        @(negedge clk); cs_n = 1'b1;
        repeat (4) @(negedge clk); cs_n = 1'b0;
        repeat (4) @(negedge clk);
        xfer_byte(1'b0, 1'b1, 8'h6D, rv, oe);
        check(mem[40] == 8'h6D, "R10 phase reset by deselect", mem[40], 8'h6D);
        strap(1'b0, 1'b0);
    endtask

    task automatic t_collide();
        logic [7:0] rv; bit oe;
        set_col(50);
        xfer_byte(1'b0, 1'b1, 8'hA1, rv, oe);
        xfer_byte(1'b0, 1'b1, 8'hA2, rv, oe);
        set_col(60);
        xfer_byte(1'b0, 1'b1, 8'hB1, rv, oe);
        set_col(50);
        xfer_byte(1'b1, 1'b1, 8'h00, rv, oe);
        // Read whose completion meets the load pulse
        @(negedge clk); cd = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        repeat (5) @(negedge clk);
        rv = dout;
        rd_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        addr_col = AW'(60);
        addr_set = 1'b1;
        @(negedge clk);
        addr_set = 1'b0;
        repeat (4) @(negedge clk);
        check(rv == 8'hA1, "R12 collided read data", rv, 8'hA1);
        check(ram_addr == 60, "R12 load wins", ram_addr, 60);
        xfer_byte(1'b1, 1'b1, 8'h00, rv, oe);
        check(ram_addr == 60, "R12 next read is throw-away", ram_addr, 60);
        xfer_byte(1'b1, 1'b1, 8'h00, rv, oe);
        check(rv == 8'hB1, "R12 valid read at loaded column", rv, 8'hB1);
    endtask

    initial begin
        for (int i = 0; i < COLS; i++) mem[i] = '0;
        t_reset();
        strap(1'b0, 1'b0);
        t_cmd_status();
        t_write();
        t_read();
        t_enable_style();
        t_deselect();
        t_wrap();
        t_nibble();
        t_resync();
        t_cs_phase();
        t_collide();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

endmodule